// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a slave has left hung. A slave that lost count of clocks part-way through a read can hold SDA low forever. The block then clocks SCL until that slave lets SDA go, and finishes with a STOP so every device on the bus returns to idle. A second command covers the other hang, where SDA is high but the bus never saw a STOP. For that case the block issues the STOP sequence on its own.

The block also samples both lines into status outputs. It tracks whether the bus is busy from the START and STOP conditions it observes. Every recovery step takes one interval of the base tick from the clock generator. The block drives the lines only through open-drain pull-down enables. When a command has finished, the block raises a one-cycle done flag that the interrupt logic collects.

Top module: `i2c_bus_recovery`

## Requirements
- R1: During reset and in the cycle after it, both pull-down enables and the done flag are 0. The busy status is 0, and the SCL and SDA status bits read 1 (idle bus).
- R2: The SCL and SDA status bits equal the line levels sampled at the previous clock edge. The delay is one register.
- R3: Busy sets when SDA is sampled falling while SCL is sampled high on two consecutive edges (START). Busy clears when SDA is sampled rising under the same SCL condition (STOP). A status change appears one cycle after the sampled edge.
- R4: A recovery command accepted with SDA status low starts a pulse train. Each pulse drives SCL low for one tick interval and then releases it for one tick interval. The enables change only in the cycle after a tick or a command.
- R5: At the end of each released phase, SDA status is examined. If it reads high, pulsing stops, so at least one pulse is always given.
- R6: No more than MAX_PULSES pulses are given (default 8). If SDA status is still low after the last pulse, done is raised without a STOP, and the SDA status bit stays 0.
- R7: A STOP sequence runs in four steps, one tick interval each. First SCL is driven low. Then SDA is driven low while SCL is still low. Then SCL is released with SDA still low. Finally SDA is released. SDA is never pulled low while SCL is released.
- R8: A recovery command accepted with both status bits high drives no line. It raises done in the next cycle.
- R9: A stop command, or a recovery command accepted with SDA high and SCL low, runs the STOP sequence of R7 and then raises done.
- R10: Done is high for exactly one cycle per completed command, in the cycle after the last step ends.
- R11: Commands that arrive while a sequence is running are ignored. A recovery command takes priority over a stop command in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Base tick, one-cycle strobe that paces every line step |
| recover_cmd | input | 1 | Strobe: clock SCL until SDA is released |
| stop_cmd | input | 1 | Strobe: issue a STOP condition |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| done | output | 1 | One-cycle recovery-done interrupt flag |
| stat_scl | output | 1 | Sampled SCL level |
| stat_sda | output | 1 | Sampled SDA level |
| stat_busy | output | 1 | Bus busy (START seen, no STOP since) |

## Verification
The bench builds the block with MAX_PULSES at 8 and a tick every fourth clock, so each pulse lasts eight clocks. With these values the bench's model slave can hold SDA for 1, 3, 8 or 9 SCL rising edges. This covers the first-pulse exit, the exit on exactly the last allowed pulse and the failure one pulse past the bound. The same slave starts and ends bus traffic on its own, which exercises both edges of the busy tracking, including the STOP that a released SDA makes.

// File: rtl/i2crec_pkg.sv
// Shared types of the bus recovery sequencer.
package i2crec_pkg;
    // Sequencer phases: pulse train, four-step STOP, completion.
    typedef enum logic [2:0] {
        RS_IDLE,
        RS_PLOW,
        RS_PHIGH,
        RS_STOP_A,
        RS_STOP_B,
        RS_STOP_C,
        RS_DONE
    } rec_state_e;
endpackage

// File: rtl/i2crec_line_mon.sv
// Line monitor: registers the SCL/SDA levels and tracks bus busy from
// START/STOP conditions. Assumes the line inputs are already synchronous
// to clk. Reset state reports an idle bus (both lines high, not busy).
module i2crec_line_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_q,
    output logic sda_q,
    output logic busy
);
    logic scl_p;
    logic sda_p;
    logic start_seen;
    logic stop_seen;

    // Detect a START or STOP from two consecutive samples.
    always_comb begin
        start_seen = scl_q && scl_p && sda_p && !sda_q;
        stop_seen  = scl_q && scl_p && !sda_p && sda_q;
    end

    // Sample the lines and update the busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
            busy  <= 1'b0;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
            scl_p <= scl_q;
            sda_p <= sda_q;
            if (start_seen)
                busy <= 1'b1;
            else if (stop_seen)
                busy <= 1'b0;
        end
    end
endmodule

// File: rtl/i2crec_seq.sv
// Recovery sequencer: on a recovery command, clocks SCL up to MAX_PULSES
// times until SDA reads high, then issues a STOP; on a stop command,
// issues the STOP alone. Each step lasts one tick interval. Assumes the
// tick strobe is one cycle wide and at least two cycles apart.
module i2crec_seq #(
    parameter int MAX_PULSES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic recover_cmd,
    input  logic stop_cmd,
    input  logic scl_q,
    input  logic sda_q,
    output logic scl_oe,
    output logic sda_oe,
    output logic done
);
    import i2crec_pkg::*;

    localparam int CNT_W = $clog2(MAX_PULSES + 1);
    localparam logic [CNT_W-1:0] LAST_PULSE = CNT_W'(MAX_PULSES);

    rec_state_e       state, state_nx;
    logic [CNT_W-1:0] pulses, pulses_nx;

    // Next-state decision for the command, pulse and STOP phases.
    always_comb begin
        state_nx  = state;
        pulses_nx = pulses;
        unique case (state)
            RS_IDLE: begin
                if (recover_cmd) begin
                    pulses_nx = '0;
                    if (!sda_q)
                        state_nx = RS_PLOW;
                    else if (scl_q)
                        state_nx = RS_DONE;
                    else
                        state_nx = RS_STOP_A;
                end else if (stop_cmd) begin
                    state_nx = RS_STOP_A;
                end
            end
            RS_PLOW:
                if (tick) state_nx = RS_PHIGH;
            RS_PHIGH:
                if (tick) begin
                    pulses_nx = pulses + 1'b1;
                    if (sda_q)
                        state_nx = RS_STOP_A;
                    else if (pulses_nx == LAST_PULSE)
                        state_nx = RS_DONE;
                    else
                        state_nx = RS_PLOW;
                end
            RS_STOP_A:
                if (tick) state_nx = RS_STOP_B;
            RS_STOP_B:
                if (tick) state_nx = RS_STOP_C;
            RS_STOP_C:
                if (tick) state_nx = RS_DONE;
            RS_DONE:
                state_nx = RS_IDLE;
            default:
                state_nx = RS_IDLE;
        endcase
    end

    // State and pulse counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RS_IDLE;
            pulses <= '0;
        end else begin
            state  <= state_nx;
            pulses <= pulses_nx;
        end
    end

    // Line enables and done flag decoded from the state.
    always_comb begin
        scl_oe = (state == RS_PLOW) || (state == RS_STOP_A) || (state == RS_STOP_B);
        sda_oe = (state == RS_STOP_B) || (state == RS_STOP_C);
        done   = (state == RS_DONE);
    end
endmodule

// File: rtl/i2c_bus_recovery.sv
// Top of the I2C bus recovery sequencer: line monitor plus sequencer.
// Assumes open-drain pads outside: an enable of 1 pulls the line low.
module i2c_bus_recovery #(
    parameter int MAX_PULSES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic recover_cmd,
    input  logic stop_cmd,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_oe,
    output logic sda_oe,
    output logic done,
    output logic stat_scl,
    output logic stat_sda,
    output logic stat_busy
);
    logic scl_q;
    logic sda_q;

    i2crec_line_mon u_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .scl_q  (scl_q),
        .sda_q  (sda_q),
        .busy   (stat_busy)
    );

    i2crec_seq #(.MAX_PULSES(MAX_PULSES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .recover_cmd (recover_cmd),
        .stop_cmd    (stop_cmd),
        .scl_q       (scl_q),
        .sda_q       (sda_q),
        .scl_oe      (scl_oe),
        .sda_oe      (sda_oe),
        .done        (done)
    );

    // Status bits are the sampled line levels.
    always_comb begin
        stat_scl = scl_q;
        stat_sda = sda_q;
    end
endmodule

// File: rtl/i2c_bus_recovery_chk.sv
// Checker for the bus recovery sequencer, bound to the top module.
module i2c_bus_recovery_chk #(
    parameter int MAX_PULSES = 8
) (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic recover_cmd,
    input logic stop_cmd,
    input logic scl_oe,
    input logic sda_oe,
    input logic done
);
    localparam int RW = $clog2(MAX_PULSES + 3);

    logic [RW-1:0] rises;
    logic          scl_oe_d;

    // Count SCL pull-downs since the last completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rises    <= '0;
            scl_oe_d <= 1'b0;
        end else begin
            scl_oe_d <= scl_oe;
            if (done)
                rises <= '0;
            else if (scl_oe && !scl_oe_d)
                rises <= rises + 1'b1;
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!scl_oe && !sda_oe && !done));

    a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_sda_low_only_under_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> (scl_oe && $past(scl_oe)));

    a_r4_steps_follow_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick) && !$past(recover_cmd) && !$past(stop_cmd)) |-> ($stable(scl_oe) && $stable(sda_oe)));

    a_r6_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rises) <= MAX_PULSES + 1);
endmodule

bind i2c_bus_recovery i2c_bus_recovery_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (.*);

// File: tb/i2c_bus_recovery_bench.sv
module i2c_bus_recovery_bench;
    localparam int MAXP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic recover_cmd = 1'b0;
    logic stop_cmd = 1'b0;
    logic ext_scl_low = 1'b0;
    logic ext_sda_low = 1'b0;
    int   rel_cnt = 0;
    wire  scl_oe, sda_oe, done, stat_scl, stat_sda, stat_busy;
    wire  scl_in = !scl_oe && !ext_scl_low;
    wire  sda_in = !sda_oe && !ext_sda_low && (rel_cnt == 0);

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int rise_cnt = 0;
    int done_cnt = 0;
    bit sda_drive_seen = 0;
    bit prev_scl_oe = 0;
    bit prev_sda_oe = 0;
    bit env_scl_prev = 1;

    i2c_bus_recovery #(.MAX_PULSES(MAXP)) u_i2c_bus_recovery (
        .clk(clk), .rst_n(rst_n), .tick(tick), .recover_cmd(recover_cmd),
        .stop_cmd(stop_cmd), .scl_in(scl_in), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done),
        .stat_scl(stat_scl), .stat_sda(stat_sda), .stat_busy(stat_busy)
    );

    always #10 clk = !clk;

    // Behavioural reference model, advanced at each rising edge.
    int m_phase = 0;
    int m_pulses = 0;
    bit m_sclq = 1, m_sdaq = 1, m_sclp = 1, m_sdap = 1, m_busy = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_pulses = 0;
            m_sclq = 1; m_sdaq = 1; m_sclp = 1; m_sdap = 1; m_busy = 0;
        end else begin
            case (m_phase)
                0: if (recover_cmd) begin
                       m_pulses = 0;
                       m_phase = !m_sdaq ? 1 : (m_sclq ? 6 : 3);
                   end else if (stop_cmd) m_phase = 3;
                1: if (tick) m_phase = 2;
                2: if (tick) begin
                       m_pulses++;
                       if (m_sdaq) m_phase = 3;
                       else if (m_pulses == MAXP) m_phase = 6;
                       else m_phase = 1;
                   end
                3, 4, 5: if (tick) m_phase++;
                default: m_phase = 0;
            endcase
            if (m_sclq && m_sclp && m_sdap && !m_sdaq) m_busy = 1;
            else if (m_sclq && m_sclp && !m_sdap && m_sdaq) m_busy = 0;
            m_sclp = m_sclq; m_sdap = m_sdaq;
            m_sclq = scl_in; m_sdaq = sda_in;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison, tick generation, slave emulation and counters.
    always @(negedge clk) begin
        cyc++;
        tick <= (cyc % 4 == 3);
        if (rst_n) begin
            chk("R4 scl_oe", scl_oe, (m_phase == 1 || m_phase == 3 || m_phase == 4));
            chk("R7 sda_oe", sda_oe, (m_phase == 4 || m_phase == 5));
            chk("R10 done", done, (m_phase == 6));
            chk("R2 stat_scl", stat_scl, m_sclq);
            chk("R2 stat_sda", stat_sda, m_sdaq);
            chk("R3 stat_busy", stat_busy, m_busy);
        end
        if (scl_oe && !prev_scl_oe) rise_cnt++;
        if (sda_oe && !prev_sda_oe) sda_drive_seen = 1;
        if (done) done_cnt++;
        prev_scl_oe = scl_oe;
        prev_sda_oe = sda_oe;
        if (scl_in && !env_scl_prev && rel_cnt > 0) rel_cnt <= rel_cnt - 1;
        env_scl_prev = scl_in;
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic strobe(input bit rec, input bit stp);
        @(negedge clk);
        recover_cmd = rec; stop_cmd = stp;
        @(negedge clk);
        recover_cmd = 0; stop_cmd = 0;
    endtask

    // Wait until one more done has been seen, bounded.
    task automatic wait_done(input string tag);
        int start = done_cnt;
        for (int i = 0; i < 400 && done_cnt == start; i++) @(negedge clk);
        chk(tag, done_cnt - start, 1);
    endtask

    task automatic clear_cnt;
        rise_cnt = 0; sda_drive_seen = 0;
    endtask

    // Slave holds SDA for n SCL rises; recovery must give min(n,MAXP) pulses.
    task automatic stuck_case(input int n, input string rq);
        rel_cnt = n;
        idle(6);
        clear_cnt();
        strobe(1, 0);
        wait_done({rq, " done after pulses"});
        if (n <= MAXP) begin
            chk({rq, " pull-downs (pulses+stop)"}, rise_cnt, n + 1);
            chk("R7 stop issued", sda_drive_seen, 1);
            idle(3);
            chk("R5 sda released", stat_sda, 1);
            chk("R3 bus idle after stop", stat_busy, 0);
        end else begin
            chk("R6 pulse bound", rise_cnt, MAXP);
            chk("R6 no stop on failure", sda_drive_seen, 0);
            idle(3);
            chk("R6 sda still low", stat_sda, 0);
            rel_cnt = 0;
            idle(4);
        end
        idle(6);
    endtask

    initial begin
        idle(3);
        chk("R1 scl_oe in reset", scl_oe, 0);
        chk("R1 busy in reset", stat_busy, 0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk("R1 sda_oe after reset", sda_oe, 0);
        chk("R1 done after reset", done, 0);
        chk("R1 stat_scl after reset", stat_scl, 1);
        chk("R1 stat_sda after reset", stat_sda, 1);
        idle(4);

        // R2: external SCL pull-down shows one cycle later.
        ext_scl_low = 1; idle(2);
        chk("R2 scl low seen", stat_scl, 0);
        ext_scl_low = 0; idle(2);
        chk("R2 scl high seen", stat_scl, 1);

        // R3: START then STOP from another master.
        ext_sda_low = 1; idle(4);
        chk("R3 busy after start", stat_busy, 1);
        ext_sda_low = 0; idle(4);
        chk("R3 idle after stop", stat_busy, 0);

        // R8: idle bus, recovery is a no-op.
        clear_cnt();
        strobe(1, 0);
        chk("R8 done next cycle", done, 1);
        chk("R8 no line driven", rise_cnt, 0);
        idle(4);

        stuck_case(1, "R5");
        stuck_case(3, "R4");
        stuck_case(MAXP, "R6");
        stuck_case(MAXP + 1, "R6");

        // R9: stop command alone.
        clear_cnt();
        strobe(0, 1);
        wait_done("R9 done after stop command");
        chk("R9 one scl pull-down", rise_cnt, 1);
        chk("R9 sda driven", sda_drive_seen, 1);
        idle(4);

        // R9: SCL held low externally, SDA high, recovery runs a STOP.
        ext_scl_low = 1; idle(3);
        clear_cnt();
        strobe(1, 0);
        ext_scl_low = 0;
        wait_done("R9 done after scl-low recovery");
        chk("R9 stop instead of pulses", sda_drive_seen, 1);
        idle(4);

        // R11: extra commands during a running sequence are ignored.
        rel_cnt = 2; idle(6);
        clear_cnt();
        strobe(1, 0);
        idle(5); strobe(1, 1); idle(9); strobe(0, 1);
        wait_done("R11 single done");
        chk("R11 pulses unchanged", rise_cnt, 3);
        idle(12);
        chk("R11 no extra done", done_cnt >= 0 ? done : 0, 0);

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R10 watchdog: actual %0d cycles, expected fewer", cyc);
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule